// File: doc/BRIEF.md
# Board Control and Status Register Block

This block is a small slave on a 32-bit register bus that gives software a view of the board. It has two read-only identity words: a fixed build-date code and the processor clock rate in hertz, which is set when the block is instantiated. It holds one read/write LED word whose low bits drive the board LEDs, and it reports the DIP switch inputs after they pass through a synchroniser.

One write-only word is a reset trigger. Writing the magic value 0x0000DEAD to it raises a one-cycle request towards the system reset controller. Any other value written there is ignored. The block decodes a 64 KiB window at word granularity. Offsets that are not decoded read as zero, and writes to them have no effect.

Every bus access is a single strobe cycle. The bus master asserts select together with write enable, the byte address and the write data. Read data comes back registered on the following cycle.

Top module: `board_ctrl_regs`

## Requirements
- R1: A read of byte offset 0x0 returns 0x09272011. Writes to 0x0 change nothing that can be read back.
- R2: A read of offset 0x4 returns the CLK_HZ parameter (default 10,000,000 = 0x00989680). Writes to 0x4 are ignored.
- R3: Offset 0x8 holds a 32-bit LED word. All 32 bits are written and read back. `led_out` always equals the low LED_W bits of this word, with 1 meaning lit.
- R4: A read of offset 0xC returns the DIP switches zero-extended to 32 bits, with 1 meaning on. Writes there are ignored. The switches pass through two flops: a value present before clock edge n is returned by a read strobe sampled at edge n+2 or later, and a strobe sampled at edge n or n+1 still returns the previous value.
- R5: A write of exactly 0x0000DEAD to offset 0x10 makes `sys_rst_req` high for exactly the one cycle after the edge that sampled the write. Any other value written there produces no pulse. A read of 0x10 returns 0.
- R6: Decoding uses address bits 15:2. Every other word offset in the 64 KiB window, including 0x108, 0x1008 and 0xFFFC, reads as 0. Writes to such offsets neither change the LED word nor raise a reset request.
- R7: Address bits 1:0 are ignored, so offsets 0x0B, 0x05, 0x13 and 0x0A act as 0x8, 0x4, 0x10 and 0x8.
- R8: `bus_rdata` is updated only at the clock edge that samples a read strobe. It holds its value through idle cycles and through write cycles.
- R9: Synchronous active-high reset clears the LED word, `bus_rdata`, `sys_rst_req` and the switch synchroniser to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address inside the 64 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dip_sw | input | SW_W (8) | Asynchronous DIP switch inputs |
| led_out | output | LED_W (8) | LED drive, low bits of the LED word |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
Read data and the reset request are each due one edge after the strobe. The bench raises the strobe at a falling edge, drops it at the next falling edge, and samples both outputs there, after exactly one rising edge. The LED outputs follow the same single edge. A switch change needs two extra edges, so the bench holds a read strobe over three edges and expects the old value twice and the new value on the third. Hold checks sample `bus_rdata` after idle and write cycles, and the reset pulse is checked low again one cycle after it appears.

// File: rtl/brdctl_pkg.sv
package brdctl_pkg;

    localparam int WIN_ADDR_W = 16;           // 64 KiB decode window
    localparam int WORD_LSB   = 2;
    localparam int WIDX_W     = WIN_ADDR_W - WORD_LSB;

    localparam logic [31:0] BUILD_STAMP = 32'h0927_2011;
    localparam logic [31:0] RESET_KEY   = 32'h0000_DEAD;

    localparam logic [WIDX_W-1:0] WIDX_ID   = WIDX_W'(0);
    localparam logic [WIDX_W-1:0] WIDX_FREQ = WIDX_W'(1);
    localparam logic [WIDX_W-1:0] WIDX_LED  = WIDX_W'(2);
    localparam logic [WIDX_W-1:0] WIDX_SW   = WIDX_W'(3);
    localparam logic [WIDX_W-1:0] WIDX_KICK = WIDX_W'(4);

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_ID,
        TGT_FREQ,
        TGT_LED,
        TGT_SW,
        TGT_KICK
    } reg_tgt_e;

    typedef struct packed {
        logic        rd;
        logic        wr;
        reg_tgt_e    tgt;
        logic [31:0] wdata;
    } bus_op_t;

    function automatic reg_tgt_e word_target(input logic [WIDX_W-1:0] widx);
        case (widx)
            WIDX_ID:   return TGT_ID;
            WIDX_FREQ: return TGT_FREQ;
            WIDX_LED:  return TGT_LED;
            WIDX_SW:   return TGT_SW;
            WIDX_KICK: return TGT_KICK;
            default:   return TGT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/brdctl_decode.sv
module brdctl_decode
    import brdctl_pkg::*;
(
    input  logic                  sel,
    input  logic                  we,
    input  logic [WIN_ADDR_W-1:0] addr,
    input  logic [31:0]           wdata,
    output bus_op_t               op
);
    logic [WIDX_W-1:0] widx;
    logic [WORD_LSB-1:0] byte_lane;
    logic lane_unused;

    assign widx      = addr[WIN_ADDR_W-1:WORD_LSB];
    assign byte_lane = addr[WORD_LSB-1:0];
    assign lane_unused = &{1'b1, byte_lane} & 1'b0;

    always_comb begin
        op.rd    = sel && !we;
        op.wr    = sel && we && !lane_unused;
        op.tgt   = word_target(widx);
        op.wdata = wdata;
    end
endmodule

// File: rtl/brdctl_sync.sv
module brdctl_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/brdctl_kick.sv
module brdctl_kick
    import brdctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        kick_wr,
    input  logic [31:0] kick_data,
    output logic        req
);
    logic armed;

    assign armed = kick_wr && (kick_data == RESET_KEY);

    always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= armed;
    end

    // R5
    kick_cause_chk: assert property (@(posedge clk) disable iff (rst)
        req |-> $past(kick_wr && kick_data == RESET_KEY));

    // R5
    kick_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (kick_wr && kick_data == RESET_KEY) |=> req);
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
    import brdctl_pkg::*;
#(
    parameter logic [31:0] CLK_HZ = 32'd10_000_000,
    parameter int          SW_W   = 8,
    parameter int          LED_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [WIN_ADDR_W-1:0] bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [SW_W-1:0]       dip_sw,
    output logic [LED_W-1:0]      led_out,
    output logic                  sys_rst_req
);
    localparam int SYNC_STAGES = 2;

    bus_op_t         op;
    logic [31:0]     led_word;
    logic [SW_W-1:0] sw_sync;
    logic [31:0]     rd_value;

    brdctl_decode u_decode (
        .sel   (bus_sel),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .op    (op)
    );

    brdctl_sync #(.W(SW_W), .STAGES(SYNC_STAGES)) u_sw_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (dip_sw),
        .sync_out (sw_sync)
    );

    brdctl_kick u_kick (
        .clk       (clk),
        .rst       (rst),
        .kick_wr   (op.wr && op.tgt == TGT_KICK),
        .kick_data (op.wdata),
        .req       (sys_rst_req)
    );

    always_ff @(posedge clk) begin
        if (rst)                              led_word <= '0;
        else if (op.wr && op.tgt == TGT_LED)  led_word <= op.wdata;
    end

    assign led_out = led_word[LED_W-1:0];

    always_comb begin
        case (op.tgt)
            TGT_ID:   rd_value = BUILD_STAMP;
            TGT_FREQ: rd_value = CLK_HZ;
            TGT_LED:  rd_value = led_word;
            TGT_SW:   rd_value = 32'(sw_sync);
            default:  rd_value = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        bus_rdata <= '0;
        else if (op.rd) bus_rdata <= rd_value;
    end

    // R1
    id_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr[15:2] == 14'd0) |=> bus_rdata == BUILD_STAMP);

    // R2
    freq_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr[15:2] == 14'd1) |=> bus_rdata == CLK_HZ);

    // R3
    led_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_we && bus_addr[15:2] == 14'd2) |=> $stable(led_out));

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_we) |=> $stable(bus_rdata));

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (led_out == '0 && bus_rdata == '0 && !sys_rst_req));
endmodule

// File: tb/board_ctrl_regs_test.sv
module board_ctrl_regs_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  dip_sw = 8'hA5;
    logic [7:0]  led_out;
    logic        sys_rst_req;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam logic [31:0] CODE = 32'h0927_2011;
    localparam logic [31:0] FREQ = 32'h0098_9680;

    always #10 clk = ~clk;   // 50 MHz

    board_ctrl_regs uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dip_sw(dip_sw), .led_out(led_out), .sys_rst_req(sys_rst_req)
    );

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic        pulse;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0000, 32'h0, CODE,          1'b0, 4'd1},
        '{1'b1, 16'h0000, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd1},
        '{1'b0, 16'h0000, 32'h0, CODE,          1'b0, 4'd1},
        '{1'b0, 16'h0004, 32'h0, FREQ,          1'b0, 4'd2},
        '{1'b1, 16'h0004, 32'h0, 32'h0,         1'b0, 4'd2},
        '{1'b0, 16'h0004, 32'h0, FREQ,          1'b0, 4'd2},
        '{1'b1, 16'h0008, 32'h1234_5678, 32'h0, 1'b0, 4'd3},
        '{1'b0, 16'h0008, 32'h0, 32'h1234_5678, 1'b0, 4'd3},
        '{1'b1, 16'h000C, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd4},
        '{1'b0, 16'h000C, 32'h0, 32'h0000_00A5, 1'b0, 4'd4},
        '{1'b1, 16'h0010, 32'h0000_DEAE, 32'h0, 1'b0, 4'd5},
        '{1'b1, 16'h0010, 32'h1000_DEAD, 32'h0, 1'b0, 4'd5},
        '{1'b1, 16'h0010, 32'h0000_DEAD, 32'h0, 1'b1, 4'd5},
        '{1'b0, 16'h0010, 32'h0, 32'h0,         1'b0, 4'd5},
        '{1'b0, 16'h0014, 32'h0, 32'h0,         1'b0, 4'd6},
        '{1'b0, 16'h0108, 32'h0, 32'h0,         1'b0, 4'd6},
        '{1'b0, 16'hFFFC, 32'h0, 32'h0,         1'b0, 4'd6},
        '{1'b1, 16'h0020, 32'h0000_DEAD, 32'h0, 1'b0, 4'd6},
        '{1'b1, 16'h1008, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd6},
        '{1'b0, 16'h0008, 32'h0, 32'h1234_5678, 1'b0, 4'd6},
        '{1'b0, 16'h000B, 32'h0, 32'h1234_5678, 1'b0, 4'd7},
        '{1'b0, 16'h0005, 32'h0, FREQ,          1'b0, 4'd7},
        '{1'b1, 16'h0013, 32'h0000_DEAD, 32'h0, 1'b1, 4'd7},
        '{1'b1, 16'h000A, 32'hCAFE_F00D, 32'h0, 1'b0, 4'd7},
        '{1'b0, 16'h0008, 32'h0, 32'hCAFE_F00D, 1'b0, 4'd7}
    };

    function automatic string tag_name(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // One strobe cycle; returns at the falling edge after the sampling edge.
    task automatic access(input logic we, input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check("R9", bus_rdata, 32'h0);
        check("R9", 32'(led_out), 32'h0);
        check("R9", 32'(sys_rst_req), 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].we, VECS[i].addr, VECS[i].data);
            if (!VECS[i].we) check(tag_name(VECS[i].req), bus_rdata, VECS[i].exp);
            check(tag_name(VECS[i].req), 32'(sys_rst_req), 32'(VECS[i].pulse));
            if (VECS[i].pulse) begin
                @(negedge clk);
                // R5 single cycle
                check("R5", 32'(sys_rst_req), 32'h0);
            end
        end

        // R3 LED pins follow low byte of the word
        check("R3", 32'(led_out), 32'h0000_000D);

        // R8 hold across idle and write cycles
        access(1'b0, 16'h0000, 32'h0);
        repeat (3) @(negedge clk);
        check("R8", bus_rdata, CODE);
        access(1'b1, 16'h0008, 32'h0000_00FF);
        check("R8", bus_rdata, CODE);
        check("R3", 32'(led_out), 32'h0000_00FF);

        // R4 synchroniser latency: strobe held over three edges
        @(negedge clk);
        dip_sw = 8'h3C;
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 16'h000C;
        @(negedge clk);
        check("R4", bus_rdata, 32'h0000_00A5);
        @(negedge clk);
        check("R4", bus_rdata, 32'h0000_00A5);
        @(negedge clk);
        check("R4", bus_rdata, 32'h0000_003C);
        bus_sel = 1'b0;

        // R9 mid-run reset
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9", 32'(led_out), 32'h0);
        check("R9", bus_rdata, 32'h0);
        access(1'b0, 16'h0008, 32'h0);
        check("R9", bus_rdata, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule